// File: doc/BRIEF.md
# Multi-Channel DMA Descriptor Sequencer

This block is the control front end of a six-channel descriptor-driven DMA engine. Software arms a channel by setting its bit in a shared trigger register and programming its control word. It also sets the address of the channel's first descriptor. A client then raises a per-channel start request. If the channel is armed, the sequencer issues a single descriptor fetch address together with a one-cycle strobe. It then waits for the descriptor engine to report completion. The report carries the chained next pointer, the two end-of-chain flags and an error flag.

Each channel keeps a finished flag that is set at reset. When the flag is set, the next fetch restarts the chain from the programmed start address. When it is clear, the fetch follows the pointer taken from the previous descriptor. A per-channel retrigger bit forces a restart from the start address. Only one descriptor is outstanding at a time. Requests that arrive while the sequencer is busy are held, and the lowest-numbered eligible channel is served first.

Top module: `dma_desc_seq`

## Requirements
- R1: The global register at byte offset 0x104 uses bit n (n = 0..5) to trigger channel n and bit 6+n to retrigger it. A write ORs data bits 11:0 into the register and never clears a bit. A read of 0x104 returns zero.
- R2: Each channel n has a control register at 0x200 + 0x100*n + 0x10. Bit 0 is enable and bit 1 is pause. Bits 29:0 are stored and bits 31:30 read back as zero. Any write to this register clears the trigger bit of channel n.
- R3: A start request is only served if the channel is triggered, enabled and not paused. Otherwise the request is dropped and no fetch strobe appears.
- R4: The fetch address is {start_hi[15:0], start_lo[31:0]} when the channel's finished flag or its retrigger bit is set. Otherwise it is the stored next-descriptor address {next_hi, next_lo}.
- R5: A retrigger bit is consumed (cleared) by a grant that finds the finished flag clear. A grant that finds the finished flag set leaves the retrigger bit in place.
- R6: Per channel, start_hi is at +0x00 and keeps only data bits 15:0, and start_lo is at +0x04. next_hi is at +0x08 (16 bits) and next_lo is at +0x0C. Both next registers ignore writes and load from cmp_next on a completion without error.
- R7: The finished flag is set by a completion that has error, last or last-of-frame set. A grant clears it. All flags are set after reset.
- R8: Only one fetch is outstanding. No new strobe appears until cmp_valid is seen. Among eligible requests the lowest channel number wins, and an eligible request that loses is served later.
- R9: fetch_vld is a one-cycle pulse in the cycle after the clock edge that samples the winning request, with fetch_addr and fetch_ch (channel number) valid alongside it.
- R10: After reset all registers read zero and fetch_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| start_req | input | 6 | Per-channel start request |
| cmp_valid | input | 1 | Descriptor completion report for the active channel |
| cmp_next | input | 48 | Next-descriptor pointer from the completed descriptor |
| cmp_last | input | 1 | Completed descriptor is the last of its chain |
| cmp_last_frame | input | 1 | Completed descriptor is the last of its frame |
| cmp_error | input | 1 | Descriptor fetch or check failed |
| fetch_vld | output | 1 | Descriptor fetch strobe |
| fetch_addr | output | 48 | Descriptor fetch address |
| fetch_ch | output | 3 | Channel of the fetch |

## Verification
The bench walks a channel through every reason to refuse a start: no trigger, pause, disable, and a trigger wiped by a control write. A design that checked only the enable bit would emit a strobe in one of those cases. It exercises the finished-flag paths of last, last-of-frame and error. A design that ignored one of them would chain to the stale pointer rather than restart, and a design that loaded the pointer on an error would show a changed next register. It also covers the asymmetric retrigger rule: a design that always cleared the bit would fail to restart a second time, and one that never cleared it would restart forever. Finally, two simultaneous requests check that the lower channel goes first and that the loser is not dropped.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   // Register map constants (byte offsets)
   localparam int unsigned REG_AW       = 12;
   localparam int unsigned GLOBAL_OFF   = 'h104;
   localparam int unsigned CH_BASE_OFF  = 'h200;
   localparam int unsigned CH_STRIDE    = 'h100;

   // Offsets inside one channel's group
   localparam logic [7:0] SUB_START_HI = 8'h00;
   localparam logic [7:0] SUB_START_LO = 8'h04;
   localparam logic [7:0] SUB_NEXT_HI  = 8'h08;
   localparam logic [7:0] SUB_NEXT_LO  = 8'h0C;
   localparam logic [7:0] SUB_CTRL     = 8'h10;

   // Control word layout
   localparam int unsigned CTRL_W         = 30;
   localparam int unsigned CTRL_EN_BIT    = 0;
   localparam int unsigned CTRL_PAUSE_BIT = 1;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;

endpackage

// File: rtl/dma_seq_glob.sv
module dma_seq_glob #(
   parameter int unsigned NUM_CH = 6,
   localparam int unsigned GW    = 2 * NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [GW-1:0]     wr_bits,
   input  logic [NUM_CH-1:0] ctrl_wr,
   input  logic [NUM_CH-1:0] consume,
   output logic [NUM_CH-1:0] trig,
   output logic [NUM_CH-1:0] retrig
);

   logic [GW-1:0] g_q;
   logic [GW-1:0] g_next;

   // Clears are applied first, so a write landing with a clear still sets its bits
   always_comb begin
      g_next = g_q & ~{consume, ctrl_wr};
      if (wr_hit) g_next = g_next | wr_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g_q <= '0;
      else        g_q <= g_next;
   end

   assign trig   = g_q[NUM_CH-1:0];
   assign retrig = g_q[GW-1:NUM_CH];

   // R1: a write only ever adds bits
   a_r1_write_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> ((g_q & $past(wr_bits)) == $past(wr_bits)))
      else $error("R1: written bit did not stick");

   // R1: bits rise only through a write
   a_r1_rise_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> ((g_q & ~$past(g_q)) == '0))
      else $error("R1: bit set without write");

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R2: control write wipes the trigger
      a_r2_ctrl_clears_trig: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_wr[i] |=> !trig[i])
         else $error("R2: trigger survived control write");
      // R5: sampled retrigger is consumed
      a_r5_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (consume[i] && !wr_hit) |=> !retrig[i])
         else $error("R5: retrigger survived consumption");
   end

endmodule

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
   parameter int unsigned N  = 6,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);

   // Scan from the top down so the lowest requester is written last
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end

   // R8: at most one winner, drawn from the requesters, and the lowest
   a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt))
      else $error("R8: multiple grants");
   a_r8_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0)
      else $error("R8: grant without request");
   a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> ((req & (gnt - 1'b1)) == '0))
      else $error("R8: lower requester skipped");

endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
   import dma_seq_pkg::*;
#(
   parameter int unsigned CH_IDX = 0,
   parameter int unsigned ADDR_W = 48,
   localparam int unsigned EXT_W = ADDR_W - 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic              rd_hit,
   output logic [31:0]       rd_data,
   input  logic              grant_i,
   input  logic              cmp_upd_i,
   input  logic [ADDR_W-1:0] cmp_next_i,
   input  logic              cmp_end_i,
   input  logic              cmp_err_i,
   output logic              ch_en,
   output logic              ch_pause,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] next_addr,
   output logic              finished,
   output logic              ctrl_wr
);

   localparam logic [3:0] PAGE = 4'((CH_BASE_OFF + CH_IDX * CH_STRIDE) >> 8);

   logic [CTRL_W-1:0] ctrl_q;
   logic [EXT_W-1:0]  start_hi_q, next_hi_q;
   logic [31:0]       start_lo_q, next_lo_q;
   logic              fin_q;

   logic wr_grp;
   assign wr_grp  = wr_en && (wr_addr[11:8] == PAGE);
   assign ctrl_wr = wr_grp && (wr_addr[7:0] == SUB_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         start_hi_q <= '0;
         start_lo_q <= '0;
         next_hi_q  <= '0;
         next_lo_q  <= '0;
         fin_q      <= 1'b1;
      end else begin
         if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
         if (wr_grp && wr_addr[7:0] == SUB_START_HI) start_hi_q <= wr_data[EXT_W-1:0];
         if (wr_grp && wr_addr[7:0] == SUB_START_LO) start_lo_q <= wr_data;
         // next pointer is owned by the descriptor engine, never by software
         if (cmp_upd_i && !cmp_err_i) begin
            next_hi_q <= cmp_next_i[ADDR_W-1:32];
            next_lo_q <= cmp_next_i[31:0];
         end
         if (grant_i)                      fin_q <= 1'b0;
         else if (cmp_upd_i && cmp_end_i)  fin_q <= 1'b1;
      end
   end

   assign ch_en      = ctrl_q[CTRL_EN_BIT];
   assign ch_pause   = ctrl_q[CTRL_PAUSE_BIT];
   assign start_addr = {start_hi_q, start_lo_q};
   assign next_addr  = {next_hi_q, next_lo_q};
   assign finished   = fin_q;

   assign rd_hit = (rd_addr[11:8] == PAGE);
   always_comb begin
      rd_data = '0;
      case (rd_addr[7:0])
         SUB_START_HI: rd_data = 32'(start_hi_q);
         SUB_START_LO: rd_data = start_lo_q;
         SUB_NEXT_HI:  rd_data = 32'(next_hi_q);
         SUB_NEXT_LO:  rd_data = next_lo_q;
         SUB_CTRL:     rd_data = 32'(ctrl_q);
         default:      rd_data = '0;
      endcase
   end

   // R3: grants reach only enabled, running channels
   a_r3_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |-> (ch_en && !ch_pause))
      else $error("R3: grant to disabled or paused channel");
   // R7: end-of-chain report marks the channel finished
   a_r7_end_sets_finished: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_upd_i && cmp_end_i) |=> finished)
      else $error("R7: finished not set");
   // R7: starting a chain clears the flag
   a_r7_grant_clears_finished: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |=> !finished)
      else $error("R7: finished not cleared at grant");
   // R6: next pointer moves only on a clean completion
   a_r6_next_only_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_upd_i && !cmp_err_i) |=> ($stable(next_lo_q) && $stable(next_hi_q)))
      else $error("R6: next pointer changed without completion");

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
   import dma_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned ADDR_W = 48,
   localparam int unsigned CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned GW    = 2 * NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [11:0]       wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [11:0]       rd_addr,
   output logic [31:0]       rd_data,
   input  logic [NUM_CH-1:0] start_req,
   input  logic              cmp_valid,
   input  logic [ADDR_W-1:0] cmp_next,
   input  logic              cmp_last,
   input  logic              cmp_last_frame,
   input  logic              cmp_error,
   output logic              fetch_vld,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [CW-1:0]     fetch_ch
);

   // Elaboration checks
   if (NUM_CH < 2 || NUM_CH > 14) begin : g_bad_num_ch
      $error("NUM_CH must lie in 2..14 to fit the register map");
   end
   if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ADDR_W must lie in 33..64");
   end
   if (GW > 32) begin : g_bad_gw
      $error("global register exceeds 32 bits");
   end

   logic [NUM_CH-1:0] ch_en, ch_pause, fin, ctrl_wr, grant, cmp_upd, rd_hit;
   logic [NUM_CH-1:0] trig, retrig, consume, elig, arb_gnt;
   logic [ADDR_W-1:0] start_a [NUM_CH];
   logic [ADDR_W-1:0] next_a  [NUM_CH];
   logic [31:0]       rd_d    [NUM_CH];
   logic [CW-1:0]     arb_idx;
   logic              arb_any;

   seq_state_e        state_q;
   logic [NUM_CH-1:0] pend_q;
   logic [CW-1:0]     act_ch_q;
   logic              fetch_vld_q;
   logic [ADDR_W-1:0] fetch_addr_q;
   logic [CW-1:0]     fetch_ch_q;

   logic              gbl_wr, cmp_end;
   logic [NUM_CH-1:0] req_all;
   logic [ADDR_W-1:0] sel_addr;

   assign gbl_wr  = wr_en && (wr_addr == REG_AW'(GLOBAL_OFF));
   assign cmp_end = cmp_error | cmp_last | cmp_last_frame;

   // ---------------- per-channel register groups ----------------
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dma_seq_chan #(
         .CH_IDX (i),
         .ADDR_W (ADDR_W)
      ) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (wr_en),
         .wr_addr    (wr_addr),
         .wr_data    (wr_data),
         .rd_addr    (rd_addr),
         .rd_hit     (rd_hit[i]),
         .rd_data    (rd_d[i]),
         .grant_i    (grant[i]),
         .cmp_upd_i  (cmp_upd[i]),
         .cmp_next_i (cmp_next),
         .cmp_end_i  (cmp_end),
         .cmp_err_i  (cmp_error),
         .ch_en      (ch_en[i]),
         .ch_pause   (ch_pause[i]),
         .start_addr (start_a[i]),
         .next_addr  (next_a[i]),
         .finished   (fin[i]),
         .ctrl_wr    (ctrl_wr[i])
      );
   end

   // ---------------- global trigger register ----------------
   dma_seq_glob #(.NUM_CH(NUM_CH)) u_glob (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (gbl_wr),
      .wr_bits (wr_data[GW-1:0]),
      .ctrl_wr (ctrl_wr),
      .consume (consume),
      .trig    (trig),
      .retrig  (retrig)
   );

   // ---------------- arbitration ----------------
   assign req_all = pend_q | start_req;
   assign elig    = req_all & trig & ch_en & ~ch_pause;

   dma_seq_arb #(.N(NUM_CH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (elig),
      .gnt   (arb_gnt),
      .idx   (arb_idx),
      .any   (arb_any)
   );

   assign grant   = (state_q == SEQ_IDLE) ? arb_gnt : '0;
   // retrigger is only looked at when the finished flag is clear
   assign consume = grant & ~fin & retrig;
   assign sel_addr = (fin[arb_idx] || retrig[arb_idx]) ? start_a[arb_idx] : next_a[arb_idx];

   always_comb begin
      cmp_upd = '0;
      if (state_q == SEQ_BUSY && cmp_valid) cmp_upd[act_ch_q] = 1'b1;
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SEQ_IDLE;
         pend_q       <= '0;
         act_ch_q     <= '0;
         fetch_vld_q  <= 1'b0;
         fetch_addr_q <= '0;
         fetch_ch_q   <= '0;
      end else begin
         fetch_vld_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               // ineligible requests are dropped, losing ones kept
               pend_q <= elig & ~arb_gnt;
               if (arb_any) begin
                  state_q      <= SEQ_BUSY;
                  act_ch_q     <= arb_idx;
                  fetch_vld_q  <= 1'b1;
                  fetch_addr_q <= sel_addr;
                  fetch_ch_q   <= arb_idx;
               end
            end
            default: begin
               pend_q <= pend_q | start_req;
               if (cmp_valid) state_q <= SEQ_IDLE;
            end
         endcase
      end
   end

   assign fetch_vld  = fetch_vld_q;
   assign fetch_addr = fetch_addr_q;
   assign fetch_ch   = fetch_ch_q;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_hit[i]) rd_data = rd_data | rd_d[i];
      end
   end

   // R8: nothing is granted while a descriptor is outstanding
   a_r8_no_grant_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_BUSY) |-> (grant == '0))
      else $error("R8: grant while busy");
   // R9: strobe lasts one cycle
   a_r9_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld_q |=> !fetch_vld_q)
      else $error("R9: strobe longer than one cycle");
   // R3: only triggered channels are granted
   a_r3_grant_is_triggered: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> ((grant & trig) == grant))
      else $error("R3: grant without trigger");

endmodule

// File: tb/tb_dma_desc_seq.sv
module tb_dma_desc_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [5:0]  start_req = '0;
   logic        cmp_valid = 1'b0;
   logic [47:0] cmp_next = '0;
   logic        cmp_last = 1'b0;
   logic        cmp_last_frame = 1'b0;
   logic        cmp_error = 1'b0;
   logic        fetch_vld;
   logic [47:0] fetch_addr;
   logic [2:0]  fetch_ch;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   dma_desc_seq dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .start_req(start_req),
      .cmp_valid(cmp_valid), .cmp_next(cmp_next), .cmp_last(cmp_last),
      .cmp_last_frame(cmp_last_frame), .cmp_error(cmp_error),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .fetch_ch(fetch_ch)
   );

   localparam logic [11:0] GLB = 12'h104;
   localparam logic [11:0] O_SHI = 12'h000, O_SLO = 12'h004, O_NHI = 12'h008,
                           O_NLO = 12'h00C, O_CTL = 12'h010;

   function automatic logic [11:0] grp(input int ch, input logic [11:0] off);
      return 12'h200 + 12'(ch) * 12'h100 + off;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
      rd_addr = a;
      #1;
      check(tag, 64'(rd_data), 64'(exp));
   endtask

   // Pulse a start and check for a fetch (or its absence)
   task automatic start_chk(input int ch, input bit exp_fetch, input logic [47:0] exp_addr,
                            input string tag);
      @(negedge clk);
      start_req = 6'(1 << ch);
      @(negedge clk);
      start_req = '0;
      check({tag, " strobe"}, 64'(fetch_vld), 64'(exp_fetch));
      if (exp_fetch) begin
         check({tag, " addr"}, 64'(fetch_addr), 64'(exp_addr));
         check({tag, " ch"}, 64'(fetch_ch), 64'(ch));
         @(negedge clk);
         check({tag, " R9 pulse width"}, 64'(fetch_vld), 64'd0);
      end else begin
         bit seen = 1'b0;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (fetch_vld) seen = 1'b1;
         end
         check({tag, " late strobe"}, 64'(seen), 64'd0);
      end
   endtask

   task automatic complete(input logic [47:0] nxt, input bit last, input bit lf, input bit err);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_next = nxt; cmp_last = last; cmp_last_frame = lf; cmp_error = err;
      @(negedge clk);
      cmp_valid = 1'b0; cmp_last = 1'b0; cmp_last_frame = 1'b0; cmp_error = 1'b0;
   endtask

   localparam logic [47:0] CH0_START = 48'h1234_1000_0000;

   task automatic t_reset();
      check("R10 fetch_vld after reset", 64'(fetch_vld), 64'd0);
      rd_chk(grp(0, O_CTL), 32'h0, "R10 ctrl0 reset");
      rd_chk(grp(3, O_NLO), 32'h0, "R10 next_lo ch3 reset");
      rd_chk(grp(5, O_SHI), 32'h0, "R10 start_hi ch5 reset");
   endtask

   task automatic t_global_read();
      wr(GLB, 32'h0000_0020);      // trigger channel 5 (left armed, unused later)
      rd_chk(GLB, 32'h0, "R1 global reads zero");
   endtask

   task automatic t_gating();
      wr(grp(0, O_SHI), 32'hABCD_1234);
      rd_chk(grp(0, O_SHI), 32'h0000_1234, "R6 start_hi keeps 16 bits");
      wr(grp(0, O_SLO), 32'h1000_0000);
      wr(grp(0, O_CTL), 32'h1);
      start_chk(0, 1'b0, '0, "R3 untriggered");
      wr(GLB, 32'h1);
      wr(grp(0, O_CTL), 32'h3);
      wr(GLB, 32'h1);
      start_chk(0, 1'b0, '0, "R3 paused");
      wr(grp(0, O_CTL), 32'h1);
      start_chk(0, 1'b0, '0, "R2 ctrl write clears trigger");
      wr(grp(0, O_CTL), 32'h0);
      wr(GLB, 32'h1);
      start_chk(0, 1'b0, '0, "R3 disabled");
      wr(grp(0, O_CTL), 32'h1);
      wr(GLB, 32'h1);
      start_chk(0, 1'b1, CH0_START, "R7 reset finished uses start R4");
      complete(48'h0055_2222_3330, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_chain();
      rd_chk(grp(0, O_NHI), 32'h0000_0055, "R6 next_hi loaded");
      rd_chk(grp(0, O_NLO), 32'h2222_3330, "R6 next_lo loaded");
      wr(grp(0, O_NLO), 32'hDEAD_BEEF);
      rd_chk(grp(0, O_NLO), 32'h2222_3330, "R6 next_lo ignores write");
      start_chk(0, 1'b1, 48'h0055_2222_3330, "R4 chained fetch");
      complete(48'h0001_0000_0040, 1'b1, 1'b0, 1'b0);
      start_chk(0, 1'b1, CH0_START, "R7 last restarts");
      complete(48'h0002_0000_0080, 1'b0, 1'b1, 1'b0);
      start_chk(0, 1'b1, CH0_START, "R7 last-of-frame restarts");
      complete(48'h7777_7777_7777, 1'b0, 1'b0, 1'b1);
      rd_chk(grp(0, O_NLO), 32'h0000_0080, "R6 error keeps next");
      start_chk(0, 1'b1, CH0_START, "R7 error restarts");
      complete(48'h0003_0000_0100, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_retrig();
      wr(GLB, 32'h40);
      start_chk(0, 1'b1, CH0_START, "R5 retrigger restarts");
      complete(48'h0004_0000_0200, 1'b0, 1'b0, 1'b0);
      start_chk(0, 1'b1, 48'h0004_0000_0200, "R5 retrigger consumed");
      complete(48'h0005_0000_0300, 1'b1, 1'b0, 1'b0);
      wr(GLB, 32'h40);
      start_chk(0, 1'b1, CH0_START, "R5 finished restart");
      complete(48'h0006_0000_0400, 1'b0, 1'b0, 1'b0);
      start_chk(0, 1'b1, CH0_START, "R5 retrigger retained");
      complete(48'h0007_0000_0500, 1'b0, 1'b0, 1'b0);
      start_chk(0, 1'b1, 48'h0007_0000_0500, "R5 retained bit now consumed");
      complete(48'h0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_ctrl_mask();
      wr(grp(1, O_CTL), 32'hFFFF_FFFF);
      rd_chk(grp(1, O_CTL), 32'h3FFF_FFFF, "R2 ctrl masked");
      wr(grp(1, O_CTL), 32'h0);
   endtask

   task automatic t_priority();
      bit busy_strobe = 1'b0;
      bit found = 1'b0;
      wr(grp(2, O_SHI), 32'h2);
      wr(grp(2, O_SLO), 32'h2000_0000);
      wr(grp(4, O_SHI), 32'h4);
      wr(grp(4, O_SLO), 32'h4000_0000);
      wr(grp(2, O_CTL), 32'h1);
      wr(grp(4, O_CTL), 32'h1);
      wr(GLB, 32'h14);
      @(negedge clk);
      start_req = 6'h14;
      @(negedge clk);
      start_req = '0;
      check("R8 lowest wins strobe", 64'(fetch_vld), 64'd1);
      check("R8 lowest wins ch", 64'(fetch_ch), 64'd2);
      check("R8 lowest wins addr", 64'(fetch_addr), 64'h0002_2000_0000);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (fetch_vld) busy_strobe = 1'b1;
      end
      check("R8 single outstanding", 64'(busy_strobe), 64'd0);
      complete(48'h0, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 4 && !found; k++) begin
         @(negedge clk);
         if (fetch_vld) found = 1'b1;
      end
      check("R8 held request served", 64'(found), 64'd1);
      check("R8 held request ch", 64'(fetch_ch), 64'd4);
      check("R8 held request addr", 64'(fetch_addr), 64'h0004_4000_0000);
      complete(48'h0, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_global_read();
      t_gating();
      t_chain();
      t_retrig();
      t_ctrl_mask();
      t_priority();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule